// File: doc/BRIEF.md
# Warm and Cold Reset Pulse Generator

This block turns a single reset request into a timed pulse for the chipset. There are two kinds of request.

A cold request pulls the system power-good line low for a fixed number of clock cycles and then lets it return high. It does this through an override output that the power sequencer combines with its own drive of that line. A cold request only acts while the power-good line is already high. If the line is low when the request arrives, the request is dropped.

A warm request pulses an emulated open-drain reset pin. The pin is normally released, with its output enable low. For the pulse, the output enable is raised while the drive value is held low. At the end of the pulse the pin is released again rather than driven high. A warm pulse never touches the power-good override.

A request is a one-cycle start strobe together with a cold/warm select. A busy flag covers the whole pulse. Any start strobe that arrives while busy is high is ignored. Both pulse widths are parameters counted in clock cycles. Their defaults are 100 µs for the cold pulse and 10 µs for the warm pulse at 50 MHz. Both defaults sit well above the chipset minimums of roughly 91 µs and 500 ns.

Top module: `rstPulseGen`

## Requirements
- R1: After reset, `busy`, `pwrOkOverride` and `rcinOe` are all low.
- R2: A start strobe with `reqCold`=1, accepted while `sysPwrOkIn`=1, raises `pwrOkOverride` from the next cycle. It stays high for exactly COLD_CYCLES cycles, and that count is at least COLD_MIN.
- R3: A start strobe with `reqCold`=1 while `sysPwrOkIn`=0 is dropped. `busy`, `pwrOkOverride` and `rcinOe` all stay low.
- R4: A start strobe with `reqCold`=0 raises `rcinOe` from the next cycle for exactly WARM_CYCLES cycles, and that count is at least WARM_MIN. `rcinDrv` is 0 whenever `rcinOe` is 1.
- R5: A warm pulse never raises `pwrOkOverride`, and a cold pulse never raises `rcinOe`.
- R6: `busy` is high in exactly the cycles where `pwrOkOverride` or `rcinOe` is high. A start strobe that arrives while `busy` is high has no effect on the running pulse or on the outputs that follow it.
- R7: A start strobe presented in the first cycle after `busy` falls is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqStart | input | 1 | One-cycle request strobe |
| reqCold | input | 1 | 1 selects a cold request, 0 a warm one |
| sysPwrOkIn | input | 1 | Current level of the system power-good line |
| busy | output | 1 | High while a pulse is running |
| pwrOkOverride | output | 1 | 1 forces the system power-good line low |
| rcinOe | output | 1 | Output enable of the open-drain reset pin |
| rcinDrv | output | 1 | Drive value of the reset pin, always 0 |

## Verification
The hardest case to reach is a start strobe that lands while a pulse is already running. It matters most when the strobe selects the other kind of reset. The stimulus therefore scatters random strobes with random selects through both kinds of pulse. It then checks that the measured width is unchanged and that the other output never moves. A directed case also fires a request in the very cycle `busy` drops, to show that the block is ready again without a gap.

// File: rtl/rstPulsePkg.sv
package rstPulsePkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COLD = 2'd1,
    ST_WARM = 2'd2
  } pulseState_t;

  typedef struct packed {
    logic loadCold;
    logic loadWarm;
  } pulseStrobe_t;
endpackage

// File: rtl/rstPulseDp.sv
module rstPulseDp
  import rstPulsePkg::*;
#(
  parameter int COLD_CYCLES = 5000,
  parameter int WARM_CYCLES = 500
) (
  input  logic         clk,
  input  logic         rstN,
  input  pulseStrobe_t strb,
  output logic         lastCycle
);
  localparam int MAX_CYCLES = (COLD_CYCLES > WARM_CYCLES) ? COLD_CYCLES : WARM_CYCLES;
  localparam int CNT_W = $clog2(MAX_CYCLES + 1);
  localparam logic [CNT_W-1:0] COLD_LOAD = CNT_W'(COLD_CYCLES - 1);
  localparam logic [CNT_W-1:0] WARM_LOAD = CNT_W'(WARM_CYCLES - 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
    end else if (strb.loadCold) begin
      remain <= COLD_LOAD;
    end else if (strb.loadWarm) begin
      remain <= WARM_LOAD;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign lastCycle = (remain == '0);
endmodule

// File: rtl/rstPulseCtl.sv
module rstPulseCtl
  import rstPulsePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqStart,
  input  logic         reqCold,
  input  logic         sysPwrOkIn,
  input  logic         lastCycle,
  output pulseStrobe_t strb,
  output logic         busy,
  output logic         coldActive,
  output logic         warmActive
);
  pulseState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqStart) begin
          if (reqCold) begin
            if (sysPwrOkIn) begin
              strb.loadCold = 1'b1;
              stateNext = ST_COLD;
            end
          end else begin
            strb.loadWarm = 1'b1;
            stateNext = ST_WARM;
          end
        end
      end
      ST_COLD, ST_WARM: begin
        if (lastCycle) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign coldActive = (state == ST_COLD);
  assign warmActive = (state == ST_WARM);
  assign busy = coldActive | warmActive;
endmodule

// File: rtl/rstPulseGen.sv
module rstPulseGen
  import rstPulsePkg::*;
#(
  parameter int COLD_CYCLES = 5000,
  parameter int WARM_CYCLES = 500,
  parameter int COLD_MIN = 4550,
  parameter int WARM_MIN = 25
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqStart,
  input  logic reqCold,
  input  logic sysPwrOkIn,
  output logic busy,
  output logic pwrOkOverride,
  output logic rcinOe,
  output logic rcinDrv
);
  pulseStrobe_t strb;
  logic lastCycle;
  logic coldActive;
  logic warmActive;

  generate
    if (COLD_CYCLES < COLD_MIN || WARM_CYCLES < WARM_MIN || WARM_CYCLES < 1) begin : g_badParam
      initial $error("pulse width parameter below its minimum");
    end
  endgenerate

  rstPulseCtl u_ctl (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqCold(reqCold),
    .sysPwrOkIn(sysPwrOkIn), .lastCycle(lastCycle), .strb(strb),
    .busy(busy), .coldActive(coldActive), .warmActive(warmActive)
  );

  rstPulseDp #(.COLD_CYCLES(COLD_CYCLES), .WARM_CYCLES(WARM_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .lastCycle(lastCycle)
  );

  assign pwrOkOverride = coldActive;
  assign rcinOe = warmActive;
  assign rcinDrv = 1'b0;
endmodule

// File: rtl/rstPulseGenChk.sv
module rstPulseGenChk #(
  parameter int COLD_MIN = 4550,
  parameter int WARM_MIN = 25
) (
  input logic clk,
  input logic rstN,
  input logic reqStart,
  input logic reqCold,
  input logic sysPwrOkIn,
  input logic busy,
  input logic pwrOkOverride,
  input logic rcinOe,
  input logic rcinDrv
);
  int coldRun;
  int warmRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coldRun <= 0;
      warmRun <= 0;
    end else begin
      coldRun <= pwrOkOverride ? coldRun + 1 : 0;
      warmRun <= rcinOe ? warmRun + 1 : 0;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rstN |=> (!busy && !pwrOkOverride && !rcinOe));

  p_cold_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrOkOverride) |-> coldRun >= COLD_MIN);

  p_cold_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqStart && reqCold && !sysPwrOkIn) |=> !busy);

  p_warm_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rcinOe) |-> warmRun >= WARM_MIN);

  p_warm_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    rcinOe |-> !rcinDrv);

  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(pwrOkOverride && rcinOe));

  p_busy_span_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy == (pwrOkOverride || rcinOe));
endmodule

bind rstPulseGen rstPulseGenChk #(.COLD_MIN(COLD_MIN), .WARM_MIN(WARM_MIN)) u_chk (
  .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqCold(reqCold),
  .sysPwrOkIn(sysPwrOkIn), .busy(busy), .pwrOkOverride(pwrOkOverride),
  .rcinOe(rcinOe), .rcinDrv(rcinDrv)
);

// File: tb/rstPulseGen_test.sv
`timescale 1ns/1ps
module rstPulseGen_test;
  localparam int COLD_CYCLES = 5000;
  localparam int WARM_CYCLES = 500;
  localparam int COLD_MIN = 4550;
  localparam int WARM_MIN = 25;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqStart = 1'b0;
  logic reqCold = 1'b0;
  logic sysPwrOkIn = 1'b1;
  logic busy, pwrOkOverride, rcinOe, rcinDrv;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rstPulseGen #(.COLD_CYCLES(COLD_CYCLES), .WARM_CYCLES(WARM_CYCLES),
                .COLD_MIN(COLD_MIN), .WARM_MIN(WARM_MIN)) uut (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqCold(reqCold),
    .sysPwrOkIn(sysPwrOkIn), .busy(busy), .pwrOkOverride(pwrOkOverride),
    .rcinOe(rcinOe), .rcinDrv(rcinDrv)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expWidth(input bit cold, input bit pwrOk);
    if (cold) return pwrOk ? COLD_CYCLES : 0;
    return WARM_CYCLES;
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      finish();
    end
  end

  // Issue a request at a negedge; held for one rising edge.
  task automatic issue(input bit cold, input bit pwrOk);
    reqStart = 1'b1;
    reqCold = cold;
    sysPwrOkIn = pwrOk;
    @(negedge clk);
    reqStart = 1'b0;
  endtask

  // Run one request and measure the pulse; noisy adds strobes during it.
  task automatic runPulse(input bit cold, input bit pwrOk, input bit noisy, input string tag);
    int width = 0;
    int wrong = 0;
    int busyBad = 0;
    int drvBad = 0;
    int expW = expWidth(cold, pwrOk);
    issue(cold, pwrOk);
    if (expW == 0) begin
      for (int i = 0; i < 4; i++) begin
        if (busy || pwrOkOverride || rcinOe) wrong++;
        @(negedge clk);
      end
      check(wrong == 0, {tag, " R3 dropped cold"}, wrong, 0);
      return;
    end
    while ((cold ? pwrOkOverride : rcinOe) && width < 20000) begin
      width++;
      if (cold ? rcinOe : pwrOkOverride) wrong++;
      if (!busy) busyBad++;
      if (rcinOe && rcinDrv) drvBad++;
      if (noisy && ($urandom_range(0, 7) == 0)) begin
        reqStart = 1'b1;
        reqCold = $urandom_range(0, 1);
        sysPwrOkIn = 1'b1;
      end else begin
        reqStart = 1'b0;
      end
      @(negedge clk);
    end
    reqStart = 1'b0;
    check(width == expW, {tag, cold ? " R2 cold width" : " R4 warm width"}, width, expW);
    check(width >= (cold ? COLD_MIN : WARM_MIN), {tag, " R2/R4 minimum"}, width, cold ? COLD_MIN : WARM_MIN);
    check(wrong == 0, {tag, " R5 other output quiet"}, wrong, 0);
    check(busyBad == 0, {tag, " R6 busy during pulse"}, busyBad, 0);
    if (!cold) check(drvBad == 0, {tag, " R4 drive low"}, drvBad, 0);
    check(!busy && !pwrOkOverride && !rcinOe, {tag, " R6 busy ends with pulse"}, busy, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!busy && !pwrOkOverride && !rcinOe, "R1 reset state", {busy, pwrOkOverride, rcinOe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !pwrOkOverride && !rcinOe, "R1 idle after reset", {busy, pwrOkOverride, rcinOe}, 0);

    runPulse(1'b1, 1'b1, 1'b0, "directed");
    runPulse(1'b0, 1'b1, 1'b0, "directed");
    runPulse(1'b1, 1'b0, 1'b0, "directed");
    runPulse(1'b0, 1'b0, 1'b0, "directed warm pwr-low");
    runPulse(1'b1, 1'b1, 1'b1, "R6 noisy cold");
    runPulse(1'b0, 1'b1, 1'b1, "R6 noisy warm");
    // R7: back-to-back request in the first idle cycle
    runPulse(1'b0, 1'b1, 1'b0, "R7 first");
    runPulse(1'b1, 1'b1, 1'b0, "R7 second");

    for (int n = 0; n < 14; n++) begin
      bit c = $urandom_range(0, 1);
      bit p = ($urandom_range(0, 3) != 0);
      repeat ($urandom_range(0, 3)) @(negedge clk);
      runPulse(c, p, $urandom_range(0, 1), "random");
    end
    finish();
  end
endmodule